// File: doc/BRIEF.md
# Period and Pulse-Width Gate Generator

This block turns an asynchronous measurement input into one clean gate pulse in the reference clock domain. A downstream counter counts reference clocks while the gate is high. In period mode the gate spans one full input cycle, from one qualifying rising edge to the next. In pulse mode it spans one phase of the input, from a rising edge to the falling edge that follows. An invert control flips the input before edge detection, so the low phase, or the interval between falling edges, can be measured with the same logic.

A one-cycle done strobe marks the end of each gate, so the counter result can be latched. Each completed gate then starts a holdoff interval of a programmable number of reference cycles. During holdoff no input edge can open a new gate, which keeps a displayed result steady long enough to read. Once holdoff has expired, the next qualifying edge starts a new measurement.

Top module: `period_gate_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, gate_o, gate_done_o and holdoff_o are all 0.
- R2: An edge on sig_i that is present at clock edge n passes through a two-stage synchronizer, and the gate change it causes is visible after clock edge n+2.
- R3: With pulse_mode_i = 0 (period mode), a qualifying rising edge opens the gate and the next rising edge closes it, so the gate is high for exactly one input period in clock cycles. Falling edges have no effect.
- R4: With pulse_mode_i = 1 (pulse mode), a rising edge opens the gate and the following falling edge closes it, so the gate is high for exactly as many cycles as the input is high.
- R5: With invert_i = 1 the input is complemented before edge detection. In pulse mode the gate then lasts as long as the low phase of sig_i. invert_i is intended to be changed only while rst_ni is low.
- R6: gate_done_o is high for exactly one cycle, and that cycle is the first cycle in which gate_o is low after a gate has ended.
- R7: holdoff_o rises in the same cycle as gate_done_o and stays high for exactly HOLDOFF_CYC cycles.
- R8: While holdoff_o is high, no input edge opens a gate, and gate_o stays 0 through the cycle after holdoff_o was last high.
- R9: After holdoff has expired, the next qualifying rising edge starts a new gate.
- R10: Asserting rst_ni low in the middle of a gate clears gate_o and holdoff_o at once, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Asynchronous measurement input |
| invert_i | input | 1 | 1 = complement the input before edge detection |
| pulse_mode_i | input | 1 | 0 = period measurement, 1 = pulse-width measurement |
| gate_o | output | 1 | Measurement gate level |
| gate_done_o | output | 1 | One-cycle strobe after the gate closes |
| holdoff_o | output | 1 | High while new gates are locked out |

## Verification
A gate change is due two clock edges after the edge that first samples the input change. gate_done_o and holdoff_o rise one edge after the last high cycle of the gate. holdoff_o then falls HOLDOFF_CYC edges later. The bench drives inputs on the falling clock edge and advances its reference model on every rising edge. It compares all three outputs at the next falling edge, so each expected value is sampled in the cycle where it is due. Directed checks of gate length, holdoff length and gate count run a few nanoseconds after a rising edge, against run-length monitors that update on the falling edge.

// File: rtl/gg_pkg.sv
package gg_pkg;
  typedef enum logic {
    MODE_PERIOD = 1'b0,
    MODE_PULSE  = 1'b1
  } meas_mode_e;
endpackage

// File: rtl/gg_edge_sync.sv
module gg_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic invert_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   prev_q;
  logic                   valid_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= sig_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1] ^ invert_i;

  // valid_q masks the first cycle so a preset polarity is not seen as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      valid_q <= 1'b1;
    end
  end

  assign rise_o = valid_q &  lvl & ~prev_q;
  assign fall_o = valid_q & ~lvl &  prev_q;
endmodule

// File: rtl/gg_holdoff.sv
module gg_holdoff #(
  parameter int unsigned HOLDOFF_CYC = 70_000_000,
  localparam int unsigned CNT_W = $clog2(HOLDOFF_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLDOFF_CYC);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/gg_gate_ctrl.sv
module gg_gate_ctrl
  import gg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       fall_i,
  input  meas_mode_e mode_i,
  input  logic       block_i,
  output logic       gate_o,
  output logic       end_o,
  output logic       done_o
);
  logic gate_q;
  logic done_q;
  logic start;
  logic stop;

  assign start = ~gate_q & rise_i & ~block_i;
  // period: toggled by rising edges; pulse: cleared by the falling edge
  assign stop  = gate_q & ((mode_i == MODE_PULSE) ? fall_i : rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= stop;
      if (start)     gate_q <= 1'b1;
      else if (stop) gate_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;
  assign end_o  = stop;
  assign done_o = done_q;
endmodule

// File: rtl/period_gate_gen.sv
module period_gate_gen
  import gg_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 70_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic invert_i,
  input  logic pulse_mode_i,
  output logic gate_o,
  output logic gate_done_o,
  output logic holdoff_o
);
  logic       rise;
  logic       fall;
  logic       gate_end;
  logic       hold;
  meas_mode_e mode;

  assign mode = meas_mode_e'(pulse_mode_i);

  gg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sig_i    (sig_i),
    .invert_i (invert_i),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  gg_gate_ctrl i_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .fall_i  (fall),
    .mode_i  (mode),
    .block_i (hold),
    .gate_o  (gate_o),
    .end_o   (gate_end),
    .done_o  (gate_done_o)
  );

  gg_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (gate_end),
    .active_o (hold)
  );

  assign holdoff_o = hold;
endmodule

// File: rtl/period_gate_gen_chk.sv
module period_gate_gen_chk #(
  parameter int unsigned HOLDOFF_CYC = 70_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_o,
  input logic gate_done_o,
  input logic holdoff_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 0;
    else if (holdoff_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_done_o |=> !gate_done_o);

  a_r6_done_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> gate_done_o);

  a_r6_done_gate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_done_o |-> !gate_o);

  a_r7_hold_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_done_o |-> holdoff_o);

  a_r7_hold_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(holdoff_o) |-> (run_q == HOLDOFF_CYC));

  a_r8_no_gate_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdoff_o |=> !gate_o);
endmodule

bind period_gate_gen period_gate_gen_chk #(.HOLDOFF_CYC(HOLDOFF_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gate_o      (gate_o),
  .gate_done_o (gate_done_o),
  .holdoff_o   (holdoff_o)
);

// File: tb/test_period_gate_gen.sv
`timescale 1ns/1ps
module test_period_gate_gen;
  localparam int unsigned HOLD = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sig_i = 1'b0;
  logic invert_i = 1'b0;
  logic pulse_mode_i = 1'b0;
  logic gate_o, gate_done_o, holdoff_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  period_gate_gen #(.HOLDOFF_CYC(HOLD)) i_period_gate_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i), .invert_i(invert_i),
    .pulse_mode_i(pulse_mode_i), .gate_o(gate_o), .gate_done_o(gate_done_o),
    .holdoff_o(holdoff_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit sq[$];
  bit m_prev, m_valid, m_gate, m_done;
  int m_hold;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq.delete(); m_prev = 0; m_valid = 0; m_gate = 0; m_done = 0; m_hold = 0;
    end else begin
      bit x, rise, fall, fin, beg;
      x = ((sq.size() == 2) ? sq[0] : 1'b0) ^ invert_i;
      rise = m_valid && x && !m_prev;
      fall = m_valid && !x && m_prev;
      fin = m_gate && (pulse_mode_i ? fall : rise);
      beg = !m_gate && rise && (m_hold == 0);
      m_done = fin;
      if (fin) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      if (beg) m_gate = 1;
      else if (fin) m_gate = 0;
      m_prev = x; m_valid = 1;
      sq.push_back(sig_i);
      if (sq.size() > 2) void'(sq.pop_front());
    end
  end

  // per-cycle comparison and run-length monitors
  int gate_run = 0, last_gate = 0, hold_run = 0, last_hold = 0, starts = 0;
  bit gate_d = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check({cur_req, " gate_o"}, gate_o, m_gate);
      check({cur_req, " gate_done_o"}, gate_done_o, m_done);
      check({cur_req, " holdoff_o"}, holdoff_o, int'(m_hold > 0));
    end
    if (gate_o) gate_run++;
    else if (gate_d) begin last_gate = gate_run; gate_run = 0; end
    if (gate_o && !gate_d) starts++;
    gate_d = gate_o;
    if (holdoff_o) hold_run++;
    else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
  end

  task automatic hi(input int n);
    repeat (n) begin @(negedge clk_i); sig_i = 1'b1; end
  endtask
  task automatic lo(input int n);
    repeat (n) begin @(negedge clk_i); sig_i = 1'b0; end
  endtask
  task automatic do_reset(input bit inv, input bit pm, input bit lvl);
    @(negedge clk_i);
    rst_ni = 1'b0; invert_i = inv; pulse_mode_i = pm; sig_i = lvl;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask
  task automatic settle;
    @(posedge clk_i); #2;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check("R1 gate in reset", gate_o, 0);
    check("R1 done in reset", gate_done_o, 0);
    check("R1 hold in reset", holdoff_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 gate after release", gate_o, 0);
    check("R1 hold after release", holdoff_o, 0);
    lo(4);

    // R2 latency, then R3 period mode
    cur_req = "R2";
    @(negedge clk_i); sig_i = 1'b1;
    repeat (2) @(posedge clk_i); #2;
    check("R2 gate before n+2", gate_o, 0);
    @(posedge clk_i); #2;
    check("R2 gate at n+2", gate_o, 1);
    cur_req = "R3";
    hi(2); lo(6);
    for (int i = 0; i < 6; i++) begin hi(4); lo(6); end
    lo(30); settle();
    check("R3 period gate length", last_gate, 10);
    check("R7 holdoff length", last_hold, HOLD);

    // R8 edges during holdoff blocked, R4 pulse width, R9 restart
    do_reset(1'b0, 1'b1, 1'b0);
    cur_req = "R4";
    lo(3); s0 = starts;
    hi(6); lo(5);
    cur_req = "R8";
    hi(3); lo(40); settle();
    check("R4 pulse gate length", last_gate, 6);
    check("R8 one gate despite edge in holdoff", starts - s0, 1);
    cur_req = "R9";
    hi(9); lo(30); settle();
    check("R9 new gate after holdoff", starts - s0, 2);
    check("R9 second pulse length", last_gate, 9);

    // R5 inverted pulse: low phase measured
    do_reset(1'b1, 1'b1, 1'b1);
    cur_req = "R5";
    hi(6); s0 = starts;
    lo(8); hi(40); settle();
    check("R5 inverted low-phase length", last_gate, 8);
    check("R5 one gate", starts - s0, 1);

    // R5 inverted period
    do_reset(1'b1, 1'b0, 1'b1);
    hi(6);
    for (int i = 0; i < 3; i++) begin lo(3); hi(9); end
    hi(30); settle();
    check("R5 inverted period length", last_gate, 12);

    // R6 done strobe observed directly
    do_reset(1'b0, 1'b1, 1'b0);
    cur_req = "R6";
    lo(3); hi(5);
    @(negedge clk_i); sig_i = 1'b0;
    wait (gate_done_o == 1'b1);
    #1; check("R6 gate low at done", gate_o, 0);
    settle();
    check("R6 done single cycle", gate_done_o, 0);
    lo(25);

    // R10 reset in mid-gate
    do_reset(1'b0, 1'b0, 1'b0);
    cur_req = "R10";
    lo(3); hi(4); lo(2);
    check("R10 gate open before reset", gate_o, 1);
    rst_ni = 1'b0; #1;
    check("R10 gate cleared", gate_o, 0);
    check("R10 hold cleared", holdoff_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    lo(10);
    check("R10 idle after reset", gate_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule